// File: doc/BRIEF.md
# Error-Resilient Slot Bit Packer

The packer takes a fixed set of variable-length coded data blocks and spreads their bits over the same number of equal-length slots. Every block begins at bit 0 of its own slot. A decoder that loses sync can therefore pick up again at the next slot boundary without any resync codewords. When a block is too long for its home slot, the bits that do not fit go into free space left by shorter blocks in other slots. A fixed offset per stage decides which slot a block searches. Bits placed in later stages are usually the less important tail of each block.

Blocks are written through a valid/ready input stream, one whole block per transfer. A `start` pulse then runs the placement, one block-and-stage step per cycle. After the placement, the packed slots leave the block bit-serially on a valid/ready output stream. The input stream only accepts data while the block is idle. The output stream holds its bit and its last flag for as long as `out_ready` stays low. `start` is a plain control pin. `busy`, `done` and `cap_err` are plain status pins.

Top module: `erec_slot_packer`

## Requirements
- R1: `in_ready` is high exactly when the block is idle, meaning it is neither placing nor streaming. A block is stored when `in_valid && in_ready`. `in_blk` selects the block, `in_len` gives its length in bits, and `in_bits[0]` is its first coded bit.
- R2: In stage 0, block i is copied into slot i starting at slot bit 0. The copy stops when the block runs out or the slot is full.
- R3: In stage n (n ≥ 1), each block that still has bits left searches slot (i + n) mod N. Blocks are handled in ascending index order within a stage. The block moves as many bits as the slot has free, taken from where it stopped reading and appended at the slot's current fill position.
- R4: A block that finds its searched slot full keeps its bits and tries the next offset in the next stage. After N stages every bit has been placed whenever the total length is at most N×S.
- R5: Slot bits that no block fills are output as 0, including bits that a previous run had filled.
- R6: A `start` whose stored total length exceeds N×S raises `cap_err`. In that case there is no placement, no `busy`, no `done` and no output. The next `start` with a legal total clears `cap_err`.
- R7: `busy` is high for exactly N×N cycles, starting the cycle after an accepted `start`. `done` is a one-cycle pulse in the cycle in which `busy` falls.
- R8: The output stream carries N×S bits: slot 0 first, and bit 0 first within each slot. `out_valid` is high from the `done` cycle up to the final transfer. `out_last` marks the final bit. While `out_valid && !out_ready`, both `out_bit` and `out_last` hold.
- R9: `start` and `in_valid` are ignored while the block is placing or streaming. The packed result is then the same as without them.
- R10: A total length of exactly N×S is accepted, and every slot ends up full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input block word offered |
| in_ready | output | 1 | Input word accepted (idle only) |
| in_blk | input | IDX_W | Index of the block being written |
| in_len | input | LEN_W | Block length in bits |
| in_bits | input | MAX_LEN | Block bits, bit 0 first |
| start | input | 1 | Pulse that begins placement |
| busy | output | 1 | Placement in progress |
| done | output | 1 | One-cycle pulse at the end of placement |
| cap_err | output | 1 | Total length exceeded slot capacity at start |
| out_valid | output | 1 | Packed bit offered |
| out_ready | input | 1 | Consumer takes the packed bit |
| out_bit | output | 1 | Packed slot bit |
| out_last | output | 1 | Marks the final packed bit |

## Verification
The assertions assume that `in_blk` is below N and `in_len` is at most MAX_LEN. They also assume that reset is released only while the block is idle with no pending stream. The bench never drives an index or a length outside those ranges. It lowers `out_ready` only while a bit is being offered and checks the held values through the stream. It pokes `start` and `in_valid` during placement on purpose to exercise R9. The overflow case is driven only from idle, so the assertion on `cap_err` sees the flag rise with placement never begun.

// File: rtl/erec_pkg.sv
package erec_pkg;

  typedef enum logic [1:0] {
    PK_IDLE  = 2'd0,
    PK_PLACE = 2'd1,
    PK_READ  = 2'd2
  } pk_state_t;

  // Slot offset searched in a given stage: a constant table, stage -> offset.
  function automatic int stage_offset(input int stage, input int n_slots);
    return stage % n_slots;
  endfunction

endpackage

// File: rtl/erec_sequencer.sv
module erec_sequencer #(
  parameter int N_SLOTS = 6,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] stage,
  output logic [IDX_W-1:0] blk,
  output logic             last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      blk   <= '0;
    end else if (clr) begin
      stage <= '0;
      blk   <= '0;
    end else if (adv) begin
      if (blk == IDX_W'(N_SLOTS - 1)) begin
        blk   <= '0;
        stage <= stage + 1'b1;
      end else begin
        blk <= blk + 1'b1;
      end
    end
  end

  assign last = (stage == IDX_W'(N_SLOTS - 1)) && (blk == IDX_W'(N_SLOTS - 1));

endmodule

// File: rtl/erec_mover.sv
module erec_mover #(
  parameter int SLOT_BITS = 7,
  parameter int MAX_LEN   = 42,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int FILL_W = $clog2(SLOT_BITS + 1)
) (
  input  logic [MAX_LEN-1:0]   src,
  input  logic [LEN_W-1:0]     rd,
  input  logic [LEN_W-1:0]     rem,
  input  logic [SLOT_BITS-1:0] dst,
  input  logic [FILL_W-1:0]    fill,
  output logic [SLOT_BITS-1:0] dst_nxt,
  output logic [LEN_W-1:0]     cnt
);

  localparam int XW = ((LEN_W > FILL_W) ? LEN_W : FILL_W) + 1;

  logic [XW-1:0] fill_x, rem_x, free_x, cnt_x;

  always_comb begin
    fill_x = XW'(fill);
    rem_x  = XW'(rem);
    free_x = XW'(SLOT_BITS) - fill_x;
    cnt_x  = (rem_x < free_x) ? rem_x : free_x;
    cnt    = LEN_W'(cnt_x);
  end

  for (genvar k = 0; k < SLOT_BITS; k++) begin : g_bit
    localparam logic [XW-1:0] KX = XW'(k);
    logic          in_win;
    logic [XW-1:0] idx;
    assign in_win     = (KX >= fill_x) && (KX < fill_x + cnt_x);
    assign idx        = XW'(rd) + KX - fill_x;
    assign dst_nxt[k] = in_win ? (|(src & (MAX_LEN'(1) << idx))) : dst[k];
  end

endmodule

// File: rtl/erec_serializer.sv
module erec_serializer #(
  parameter int TOTAL = 42,
  localparam int PW = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic [PW-1:0] pos,
  output logic          finish
);

  assign out_valid = active;
  assign out_last  = active && (pos == PW'(TOTAL - 1));
  assign finish    = out_valid && out_ready && out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pos <= '0;
    else if (!active)               pos <= '0;
    else if (out_valid && out_ready) pos <= out_last ? '0 : pos + 1'b1;
  end

endmodule

// File: rtl/erec_slot_packer.sv
module erec_slot_packer
  import erec_pkg::*;
#(
  parameter int N_SLOTS   = 6,
  parameter int SLOT_BITS = 7,
  parameter int MAX_LEN   = N_SLOTS * SLOT_BITS,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IDX_W-1:0]   in_blk,
  input  logic [LEN_W-1:0]   in_len,
  input  logic [MAX_LEN-1:0] in_bits,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               cap_err,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_bit,
  output logic               out_last
);

  localparam int FILL_W = $clog2(SLOT_BITS + 1);
  localparam int CAP    = N_SLOTS * SLOT_BITS;
  localparam int TOT_W  = $clog2(N_SLOTS * MAX_LEN + 1);
  localparam int PW     = (CAP > 1) ? $clog2(CAP) : 1;

  pk_state_t state;

  logic [MAX_LEN-1:0]   blk_bits_q [N_SLOTS];
  logic [LEN_W-1:0]     blk_len_q  [N_SLOTS];
  logic [LEN_W-1:0]     rem_q      [N_SLOTS];
  logic [LEN_W-1:0]     rd_q       [N_SLOTS];
  logic [SLOT_BITS-1:0] slot_q     [N_SLOTS];
  logic [FILL_W-1:0]    fill_q     [N_SLOTS];
  logic [CAP-1:0]       slot_flat;

  logic [IDX_W-1:0] seq_stage, seq_blk, tgt;
  logic             seq_last, go, ser_finish;
  logic [TOT_W-1:0] total;
  logic [SLOT_BITS-1:0] mv_dst;
  logic [LEN_W-1:0]     mv_cnt;
  logic [PW-1:0]        rd_pos;

  assign in_ready = (state == PK_IDLE);
  assign busy     = (state == PK_PLACE);
  assign go       = in_ready && start && (total <= TOT_W'(CAP));

  always_comb begin
    total = '0;
    for (int i = 0; i < N_SLOTS; i++) total = total + TOT_W'(blk_len_q[i]);
  end

  // Slot searched by the current block in the current stage.
  always_comb begin
    int t;
    t   = (int'(seq_blk) + stage_offset(int'(seq_stage), N_SLOTS)) % N_SLOTS;
    tgt = IDX_W'(t);
  end

  erec_sequencer #(.N_SLOTS(N_SLOTS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (go),
    .adv   (busy),
    .stage (seq_stage),
    .blk   (seq_blk),
    .last  (seq_last)
  );

  erec_mover #(.SLOT_BITS(SLOT_BITS), .MAX_LEN(MAX_LEN)) u_mover (
    .src     (blk_bits_q[seq_blk]),
    .rd      (rd_q[seq_blk]),
    .rem     (rem_q[seq_blk]),
    .dst     (slot_q[tgt]),
    .fill    (fill_q[tgt]),
    .dst_nxt (mv_dst),
    .cnt     (mv_cnt)
  );

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_flat
    assign slot_flat[g*SLOT_BITS +: SLOT_BITS] = slot_q[g];
  end

  erec_serializer #(.TOTAL(CAP)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (state == PK_READ),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .pos       (rd_pos),
    .finish    (ser_finish)
  );

  assign out_bit = out_valid && slot_flat[rd_pos];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PK_IDLE;
      done    <= 1'b0;
      cap_err <= 1'b0;
      for (int i = 0; i < N_SLOTS; i++) begin
        blk_bits_q[i] <= '0;
        blk_len_q[i]  <= '0;
        rem_q[i]      <= '0;
        rd_q[i]       <= '0;
        slot_q[i]     <= '0;
        fill_q[i]     <= '0;
      end
    end else begin
      done <= 1'b0;
      unique case (state)
        PK_IDLE: begin
          if (in_valid && (int'(in_blk) < N_SLOTS)) begin
            blk_bits_q[in_blk] <= in_bits;
            blk_len_q[in_blk]  <= in_len;
          end
          if (start) begin
            if (total > TOT_W'(CAP)) begin
              cap_err <= 1'b1;
            end else begin
              cap_err <= 1'b0;
              state   <= PK_PLACE;
              for (int i = 0; i < N_SLOTS; i++) begin
                rem_q[i]  <= blk_len_q[i];
                rd_q[i]   <= '0;
                slot_q[i] <= '0;
                fill_q[i] <= '0;
              end
            end
          end
        end
        PK_PLACE: begin
          slot_q[tgt]     <= mv_dst;
          fill_q[tgt]     <= fill_q[tgt] + FILL_W'(mv_cnt);
          rem_q[seq_blk]  <= rem_q[seq_blk] - mv_cnt;
          rd_q[seq_blk]   <= rd_q[seq_blk] + mv_cnt;
          if (seq_last) begin
            state <= PK_READ;
            done  <= 1'b1;
          end
        end
        PK_READ: begin
          if (ser_finish) state <= PK_IDLE;
        end
        default: state <= PK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/erec_checker.sv
module erec_checker #(
  parameter int N_SLOTS = 6
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic busy,
  input logic done,
  input logic cap_err,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_last
);

  localparam int RUN   = N_SLOTS * N_SLOTS;
  localparam int CNT_W = $clog2(RUN + 2);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!busy && !out_valid));

  assert_busy_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < CNT_W'(RUN)));

  assert_done_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && run_cnt == CNT_W'(RUN)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ends_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_done_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

  assert_err_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_err) |-> (!busy && !out_valid && in_ready));

endmodule

bind erec_slot_packer erec_checker #(.N_SLOTS(N_SLOTS)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .busy      (busy),
  .done      (done),
  .cap_err   (cap_err),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .out_last  (out_last)
);

// File: tb/test_erec_slot_packer.sv
module test_erec_slot_packer;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 6;
  localparam int S  = 7;
  localparam int ML = N * S;
  localparam int NS = N * S;
  localparam int IW = $clog2(N);
  localparam int LW = $clog2(ML + 1);
  localparam int NCASE = 6;

  // lengths per block, blocks 0..5
  localparam logic [5:0] LENS [NCASE][N] = '{
    '{6'd11, 6'd9, 6'd4, 6'd3, 6'd8, 6'd5},
    '{6'd7,  6'd7, 6'd7, 6'd7, 6'd7, 6'd7},
    '{6'd1,  6'd2, 6'd3, 6'd4, 6'd5, 6'd6},
    '{6'd30, 6'd2, 6'd2, 6'd2, 6'd2, 6'd2},
    '{6'd0,  6'd0, 6'd0, 6'd0, 6'd0, 6'd42},
    '{6'd0,  6'd0, 6'd0, 6'd0, 6'd0, 6'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IW-1:0] in_blk = '0;
  logic [LW-1:0] in_len = '0;
  logic [ML-1:0] in_bits = '0;
  logic start = 1'b0;
  logic busy, done, cap_err;
  logic out_valid, out_bit, out_last;
  logic out_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erec_slot_packer #(.N_SLOTS(N), .SLOT_BITS(S)) i_erec_slot_packer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_blk(in_blk), .in_len(in_len), .in_bits(in_bits),
    .start(start), .busy(busy), .done(done), .cap_err(cap_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog R7: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ML-1:0] pattern(input int b, input int c);
    logic [ML-1:0] v;
    for (int j = 0; j < ML; j++) v[j] = (((b * 5 + j * 3 + c * 7 + j / 4) % 3) == 0);
    return v;
  endfunction

  // Independent placement model built from R2..R5
  task automatic model(input logic [5:0] l [N], input logic [ML-1:0] bb [N],
                       output logic [NS-1:0] o);
    int fill [N];
    int rem [N];
    int rd [N];
    o = '0;
    for (int b = 0; b < N; b++) begin fill[b] = 0; rem[b] = int'(l[b]); rd[b] = 0; end
    for (int st = 0; st < N; st++) begin
      for (int b = 0; b < N; b++) begin
        int s, c;
        s = (b + st) % N;
        c = (rem[b] < S - fill[s]) ? rem[b] : S - fill[s];
        for (int k = 0; k < c; k++) o[s * S + fill[s] + k] = bb[b][rd[b] + k];
        fill[s] = fill[s] + c;
        rem[b]  = rem[b] - c;
        rd[b]   = rd[b] + c;
      end
    end
  endtask

  task automatic load_block(input int b, input int len, input logic [ML-1:0] bits);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_blk   = IW'(b);
    in_len   = LW'(len);
    in_bits  = bits;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_case(input int c, input logic [5:0] l [N], input bit bp, input bit poke);
    logic [ML-1:0] bb [N];
    logic [NS-1:0] exp_o, act_o;
    int bcount, rdybad, got, lastbad, k;
    for (int b = 0; b < N; b++) begin
      bb[b] = pattern(b, c);
      load_block(b, int'(l[b]), bb[b]);
    end
    model(l, bb, exp_o);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bcount = 0; rdybad = 0;
    while (!done) begin
      if (busy) bcount++;
      if (busy && in_ready) rdybad++;
      if (poke && bcount == 5) begin
        // R9: start and a rogue block write during placement must be ignored
        start = 1'b1; in_valid = 1'b1; in_blk = '0; in_len = LW'(1); in_bits = '1;
      end else begin
        start = 1'b0; in_valid = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0;
    check(bcount == N * N, "R7", "busy cycles", 64'(bcount), 64'(N * N));
    check(!busy && !cap_err, "R7", "done with busy low, no cap_err (R6 cleared)",
          {62'd0, busy, cap_err}, 64'd0);
    check(rdybad == 0, "R1", "in_ready low while placing", 64'(rdybad), 64'd0);
    // R8 readout stream, out_valid expected right at the done cycle
    act_o = '0; got = 0; lastbad = 0; k = 0;
    while (got < NS) begin
      out_ready = bp ? ((k % 3) != 1) : 1'b1;
      if (out_valid && out_ready) begin
        act_o[got] = out_bit;
        if (out_last != (got == NS - 1)) lastbad++;
        got++;
      end
      k++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(act_o == exp_o, poke ? "R9" : "R3",
          "packed slots (R2 R3 R4 R5 R10)", 64'(act_o), 64'(exp_o));
    check(lastbad == 0 && !out_valid && in_ready, "R8", "last flag and stream end",
          {32'(lastbad), 30'd0, out_valid, in_ready}, 64'd1);
  endtask

  initial begin
    logic [5:0] ovf [N];
    int seen_done, seen_busy;
    repeat (3) @(negedge clk);
    check(!busy && !done && !cap_err && !out_valid && in_ready, "R1", "reset state",
          {59'd0, busy, done, cap_err, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < NCASE; c++) run_case(c, LENS[c], (c % 2) == 1, c == 0);

    // R6: total one bit above capacity
    ovf = '{6'd8, 6'd7, 6'd7, 6'd7, 6'd7, 6'd7};
    for (int b = 0; b < N; b++) load_block(b, int'(ovf[b]), pattern(b, 9));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen_done = 0; seen_busy = 0;
    for (int i = 0; i < 10; i++) begin
      if (done) seen_done++;
      if (busy || out_valid) seen_busy++;
      @(negedge clk);
    end
    check(cap_err && seen_done == 0 && seen_busy == 0 && in_ready, "R6",
          "overflow rejected", {32'(seen_busy), 16'(seen_done), 15'd0, cap_err}, 64'd1);

    // R6: legal run afterwards clears the flag; R10 full capacity again
    run_case(1, LENS[1], 1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule